// File: doc/BRIEF.md
# Two-Phase Synapse Training Sequencer

This block is the digital controller for the online Hebbian update of the proximal synapses of one mini-column. When the overlap phase ends, a start pulse arrives together with a learn enable, the column's winner flag and the synapse-activity vector. If all three qualify the request, the block captures one flag per synapse. The flag records whether that synapse saw an active input bit. The block then runs a fixed two-cycle training burst.

The burst has two cycles of opposite polarity. In the first cycle only the synapses whose flag is clear are driven, so that their strength falls. In the second cycle only the synapses whose flag is set are driven, with the column-terminal select reversed, so that their strength rises. In both cycles every synapse that is not being trained has its tri-state driver released, which keeps sneak currents out of the array. A one-cycle done pulse follows the burst. Outside a burst, every driver is enabled and presents the live input bits at normal logic levels, which is the read path used during overlap.

Top module: `syn_train_seq`

## Requirements
- R1: A start pulse is accepted only when the sequencer is idle and both learn enable and winner are high. The cycle after an accepted start is the decrement cycle.
- R2: A start with winner low produces no training cycle. The strobe stays high, done stays low and all drivers stay enabled.
- R3: A start with learn enable low produces no training cycle. The strobe stays high, done stays low and all drivers stay enabled.
- R4: Per-synapse flags are captured from the activity vector (1 = active input) at the accepted start. Later changes of the activity vector do not alter the drive during the burst.
- R5: In the decrement cycle, drive-enable bit i equals the inverse of flag i, and every drive-value bit is 0.
- R6: In the increment cycle, drive-enable bit i equals flag i, and every drive-value bit is 1.
- R7: The active-low training strobe is low in exactly the two burst cycles and high at all other times.
- R8: The 2-bit column-select output is 2'b10 in the decrement cycle, 2'b01 in the increment cycle and 2'b00 otherwise.
- R9: Done is high for exactly one cycle, the cycle that follows the increment cycle. The sequencer is idle in the cycle after that.
- R10: Outside the burst, every drive-enable bit is 1 and the drive value equals the live activity vector.
- R11: A start that arrives during the burst or during the done cycle is ignored. The sequence is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to train after the overlap phase |
| learn_en_i | input | 1 | Learning enable |
| winner_i | input | 1 | Column won the inhibition competition |
| syn_act_i | input | N_SYN | Per-synapse input activity |
| drv_val_o | output | N_SYN | Per-synapse driver value |
| drv_en_o | output | N_SYN | Per-synapse driver enable (0 = high impedance) |
| train_n_o | output | 1 | Training strobe, active low |
| col_sel_o | output | 2 | Column-terminal select (10 = decrement, 01 = increment) |
| done_o | output | 1 | One-cycle end-of-update pulse |

## Verification
Random activity vectors from a fixed seed are used, together with the directed all-zero, all-one and alternating vectors. These patterns separate a swapped or shared enable between the two burst cycles from a correct complementary split. Each accepted start is followed by a scrambled activity vector. This shows whether the burst uses the captured flags or the live bits. Starts with winner low, with learn disabled, and repeated starts inside a burst distinguish correct gating from a sequencer that trains too eagerly or restarts.

// File: rtl/syn_train_pkg.sv
package syn_train_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEC  = 2'd1,
    ST_INC  = 2'd2,
    ST_DONE = 2'd3
  } train_state_e;

  localparam logic [1:0] COL_SEL_OFF = 2'b00;
  localparam logic [1:0] COL_SEL_DEC = 2'b10;
  localparam logic [1:0] COL_SEL_INC = 2'b01;
endpackage

// File: rtl/syn_flag_bank.sv
module syn_flag_bank #(
  parameter int N_SYN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [N_SYN-1:0] act_i,
  output logic [N_SYN-1:0] flag_o
);
  for (genvar i = 0; i < N_SYN; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_o[i] <= 1'b0;
      else if (load_i) flag_o[i] <= act_i[i];
    end
  end
endmodule

// File: rtl/syn_train_fsm.sv
module syn_train_fsm
  import syn_train_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         learn_en_i,
  input  logic         winner_i,
  output logic         accept_o,
  output train_state_e state_o
);
  train_state_e state_d;

  assign accept_o = (state_o == ST_IDLE) && start_i && learn_en_i && winner_i;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE: if (accept_o) state_d = ST_DEC;
      ST_DEC:  state_d = ST_INC;
      ST_INC:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/syn_drv_mux.sv
module syn_drv_mux
  import syn_train_pkg::*;
#(
  parameter int N_SYN = 32
) (
  input  train_state_e     state_i,
  input  logic [N_SYN-1:0] flag_i,
  input  logic [N_SYN-1:0] act_i,
  output logic [N_SYN-1:0] drv_val_o,
  output logic [N_SYN-1:0] drv_en_o
);
  logic in_dec, in_inc;
  assign in_dec = (state_i == ST_DEC);
  assign in_inc = (state_i == ST_INC);

  for (genvar i = 0; i < N_SYN; i++) begin : g_drv
    always_comb begin
      if (in_dec) begin
        drv_en_o[i]  = ~flag_i[i];
        drv_val_o[i] = 1'b0;
      end else if (in_inc) begin
        drv_en_o[i]  = flag_i[i];
        drv_val_o[i] = 1'b1;
      end else begin
        drv_en_o[i]  = 1'b1;
        drv_val_o[i] = act_i[i];
      end
    end
  end
endmodule

// File: rtl/syn_train_seq.sv
module syn_train_seq
  import syn_train_pkg::*;
#(
  parameter int N_SYN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             learn_en_i,
  input  logic             winner_i,
  input  logic [N_SYN-1:0] syn_act_i,
  output logic [N_SYN-1:0] drv_val_o,
  output logic [N_SYN-1:0] drv_en_o,
  output logic             train_n_o,
  output logic [1:0]       col_sel_o,
  output logic             done_o
);
  train_state_e     state_q;
  logic             accept;
  logic [N_SYN-1:0] flag_q;

  syn_train_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .learn_en_i (learn_en_i),
    .winner_i   (winner_i),
    .accept_o   (accept),
    .state_o    (state_q)
  );

  syn_flag_bank #(.N_SYN(N_SYN)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .act_i  (syn_act_i),
    .flag_o (flag_q)
  );

  syn_drv_mux #(.N_SYN(N_SYN)) u_mux (
    .state_i   (state_q),
    .flag_i    (flag_q),
    .act_i     (syn_act_i),
    .drv_val_o (drv_val_o),
    .drv_en_o  (drv_en_o)
  );

  always_comb begin
    unique case (state_q)
      ST_DEC:  col_sel_o = COL_SEL_DEC;
      ST_INC:  col_sel_o = COL_SEL_INC;
      default: col_sel_o = COL_SEL_OFF;
    endcase
  end

  assign train_n_o = ~((state_q == ST_DEC) || (state_q == ST_INC));
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/syn_train_seq_chk.sv
module syn_train_seq_chk
  import syn_train_pkg::*;
#(
  parameter int N_SYN = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             learn_en_i,
  input logic             winner_i,
  input train_state_e     state_q,
  input logic [N_SYN-1:0] drv_en_o,
  input logic             train_n_o,
  input logic [1:0]       col_sel_o,
  input logic             done_o
);
  logic idle;
  assign idle = (state_q == ST_IDLE);

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && learn_en_i && winner_i) |=> (col_sel_o == COL_SEL_DEC && !train_n_o));

  assert_no_win_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !winner_i) |=> train_n_o);

  assert_no_learn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !learn_en_i) |=> train_n_o);

  assert_split_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_sel_o == COL_SEL_INC) |-> (drv_en_o == ~$past(drv_en_o)));

  assert_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_sel_o == COL_SEL_DEC) |=> (col_sel_o == COL_SEL_INC));

  assert_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_sel_o == COL_SEL_INC) |=> (done_o && train_n_o));

  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_drv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_n_o |-> (&drv_en_o));
endmodule

bind syn_train_seq syn_train_seq_chk #(.N_SYN(N_SYN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .learn_en_i (learn_en_i),
  .winner_i   (winner_i),
  .state_q    (state_q),
  .drv_en_o   (drv_en_o),
  .train_n_o  (train_n_o),
  .col_sel_o  (col_sel_o),
  .done_o     (done_o)
);

// File: tb/sim_syn_train_seq.sv
module sim_syn_train_seq;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         learn = 1'b0;
  logic         win = 1'b0;
  logic [N-1:0] act = '0;
  logic [N-1:0] drv_val, drv_en;
  logic         train_n, done;
  logic [1:0]   col_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  syn_train_seq #(.N_SYN(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .learn_en_i(learn),
    .winner_i(win), .syn_act_i(act), .drv_val_o(drv_val), .drv_en_o(drv_en),
    .train_n_o(train_n), .col_sel_o(col_sel), .done_o(done)
  );

  function automatic logic [N+N+4-1:0] pack_exp(input logic [N-1:0] val,
      input logic [N-1:0] en, input logic tn, input logic [1:0] cs, input logic dn);
    return {val, en, tn, cs, dn};
  endfunction

  function automatic logic [N+N+4-1:0] exp_idle(input logic [N-1:0] a);
    return pack_exp(a, '1, 1'b1, 2'b00, 1'b0);
  endfunction

  function automatic logic [N+N+4-1:0] exp_dec(input logic [N-1:0] f);
    return pack_exp('0, ~f, 1'b0, 2'b10, 1'b0);
  endfunction

  function automatic logic [N+N+4-1:0] exp_inc(input logic [N-1:0] f);
    return pack_exp('1, f, 1'b0, 2'b01, 1'b0);
  endfunction

  function automatic logic [N+N+4-1:0] exp_done(input logic [N-1:0] a);
    return pack_exp(a, '1, 1'b1, 2'b00, 1'b1);
  endfunction

  task automatic check(input string req, input logic [N+N+4-1:0] expv);
    logic [N+N+4-1:0] got;
    #1;
    got = {drv_val, drv_en, train_n, col_sel, done};
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  // accepted burst; optional start re-asserted inside the burst
  task automatic burst(input logic [N-1:0] a, input bit restart);
    logic [N-1:0] flags;
    @(negedge clk);
    start = 1'b1; learn = 1'b1; win = 1'b1; act = a; flags = a;
    @(negedge clk);
    start = restart; act = $urandom();
    check("R1 R5 R4 dec", exp_dec(flags));
    @(negedge clk);
    act = $urandom();
    check("R6 R7 R8 inc", exp_inc(flags));
    @(negedge clk);
    act = $urandom();
    check("R9 done", exp_done(act));
    @(negedge clk);
    start = 1'b0;
    check(restart ? "R11 no restart" : "R10 idle after", exp_idle(act));
  endtask

  task automatic refused(input bit l, input bit w, input string req);
    @(negedge clk);
    start = 1'b1; learn = l; win = w; act = $urandom();
    @(negedge clk);
    start = 1'b0; act = $urandom();
    check(req, exp_idle(act));
    @(negedge clk);
    check(req, exp_idle(act));
  endtask

  initial begin
    void'($urandom(32'd4242));
    #5;
    check("R10 reset", exp_idle('0));
    @(negedge clk);
    rst_n = 1'b1;
    act = 32'hdead_beef;
    check("R10 live read", exp_idle(act));
    burst('0, 1'b0);
    burst('1, 1'b0);
    burst(32'haaaa_5555, 1'b0);
    refused(1'b1, 1'b0, "R2 non-winner");
    refused(1'b0, 1'b1, "R3 learn off");
    refused(1'b0, 1'b0, "R3 R2 both off");
    burst(32'h1234_5678, 1'b1);
    for (int k = 0; k < 20; k++) begin
      if (($urandom() % 4) == 0) refused(1'b0, ($urandom() % 2) == 1, "R3 random");
      else burst($urandom(), ($urandom() % 2) == 1);
    end
    burst($urandom(), 1'b0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule